// File: doc/BRIEF.md
# Sub-word Access Read-Modify-Write Adapter

This adapter lets a requester issue 1-, 2- and 4-byte reads and writes to a register port that only handles whole 32-bit words at word-aligned addresses. The downstream port has no byte enables. A read fetches the word that contains the requested bytes, moves those bytes down to bit 0 and clears every bit above them. A narrow write first reads the containing word, replaces only the addressed byte lanes, and writes the whole word back. A full-word write goes straight to the port with no read. A request with an illegal size or alignment is answered at once with an error flag and never reaches the port.

On the requester side a request is accepted on a valid/ready handshake. The adapter answers with a one-cycle `rsp_valid` pulse that carries the read data and the error flag. On the downstream side each request is held until `dn_ready` is seen. Each one is then completed by a `dn_rvalid` pulse, which may arrive any number of cycles later but no earlier than the cycle after acceptance. For a read, that pulse carries `dn_rdata`. For a write, it is the acknowledge.

The controller has six states:
- IDLE waits for a request.
- RD_REQ issues the read.
- RD_WAIT waits for the read data.
- WR_REQ issues the write.
- WR_WAIT waits for the write acknowledge.
- RESP drives the response.

The transitions are:
- IDLE→RESP for an illegal request.
- IDLE→RD_REQ for a read or a narrow write.
- IDLE→WR_REQ for a full-word write.
- RD_REQ→RD_WAIT on `dn_ready`.
- RD_WAIT→RESP on `dn_rvalid` for a read.
- RD_WAIT→WR_REQ on `dn_rvalid` for a narrow write.
- WR_REQ→WR_WAIT on `dn_ready`.
- WR_WAIT→RESP on `dn_rvalid`.
- RESP→IDLE always.

Top module: `subword_rmw_bridge`

## Requirements
- R1: Every downstream request uses the request address with its two low bits forced to zero.
- R2: The size code on `req_size` is 0 for one byte, 1 for two bytes and 2 for four bytes. A read returns the fetched word shifted right by 8 times `req_addr[1:0]`, masked to its low 8, 16 or 32 bits according to the size, and zero-extended to 32 bits on `rsp_rdata`.
- R3: Three kinds of request are illegal: size code 3, size code 1 with `req_addr[0]`=1, and size code 2 with `req_addr[1:0]`≠0. All other combinations are legal.
- R4: An illegal request gets its response in the cycle after acceptance with `rsp_err`=1 and `rsp_rdata`=0, and issues no downstream request. A legal request responds with `rsp_err`=0.
- R5: A legal 1- or 2-byte write issues one downstream read and then one downstream write. The written word equals the fetched word with only the addressed byte lanes replaced by the low bytes of `req_wdata`.
- R6: A legal 4-byte write issues exactly one downstream write of `req_wdata` and no read.
- R7: `req_ready` is high only when the adapter is idle, so no new request is taken until the previous response. Every accepted request produces exactly one single-cycle `rsp_valid` pulse.
- R8: A downstream request keeps `dn_valid`, `dn_write`, `dn_addr` and `dn_wdata` steady until `dn_ready` is high, and any response latency of one cycle or more is tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Illegal size or alignment |
| rsp_rdata | output | 32 | Zero-extended read data |
| dn_valid | output | 1 | Downstream word request |
| dn_ready | input | 1 | Downstream request accepted |
| dn_write | output | 1 | Downstream request is a write |
| dn_addr | output | ADDR_W | Word-aligned downstream address |
| dn_wdata | output | 32 | Downstream write word |
| dn_rvalid | input | 1 | Downstream read data or write acknowledge |
| dn_rdata | input | 32 | Downstream read word |

## Verification
The bench sweeps all 16 byte offsets of a four-word window against all four size codes, once as reads and once as writes. This covers every legal and illegal combination, every byte lane and every shift amount. Downstream read and write counts tell apart the plain read, the read-then-write merge, the direct full-word write and the rejected request. Response latency and `dn_ready` stalls are varied from request to request, so the hold and wait paths are exercised. A final full-word read-back of each word compares against an arithmetically maintained shadow, which shows that untouched lanes survived every merge.

// File: rtl/subword_rmw_pkg.sv
package subword_rmw_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;
    localparam int OFS_W  = $clog2(LANES);

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_RESP
    } rmw_state_t;

    function automatic logic [WORD_W-1:0] size_mask(input logic [1:0] sz);
        logic [WORD_W-1:0] m;
        unique case (sz)
            SZ_BYTE: m = {{(WORD_W-8){1'b0}}, 8'hFF};
            SZ_HALF: m = {{(WORD_W-16){1'b0}}, 16'hFFFF};
            default: m = '1;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/rmw_legal_check.sv
module rmw_legal_check
    import subword_rmw_pkg::*;
(
    input  logic [OFS_W-1:0] ofs,
    input  logic [1:0]       size,
    output logic             legal
);
    always_comb begin
        unique case (size)
            SZ_BYTE: legal = 1'b1;
            SZ_HALF: legal = (ofs[0] == 1'b0);
            SZ_WORD: legal = (ofs == '0);
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/rmw_lane_extract.sv
module rmw_lane_extract
    import subword_rmw_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [1:0]        size,
    output logic [WORD_W-1:0] data
);
    logic [WORD_W-1:0] shifted;
    always_comb begin
        shifted = word >> (8 * ofs);
        data    = shifted & size_mask(size);
    end
endmodule

// File: rtl/rmw_lane_merge.sv
module rmw_lane_merge
    import subword_rmw_pkg::*;
(
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] new_data,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [1:0]        size,
    output logic [WORD_W-1:0] merged
);
    logic [WORD_W-1:0] lane_mask;
    logic [WORD_W-1:0] placed;
    always_comb begin
        lane_mask = size_mask(size) << (8 * ofs);
        placed    = (new_data & size_mask(size)) << (8 * ofs);
        merged    = (old_word & ~lane_mask) | placed;
    end
endmodule

// File: rtl/subword_rmw_bridge.sv
module subword_rmw_bridge
    import subword_rmw_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [WORD_W-1:0] dn_wdata,
    input  logic              dn_rvalid,
    input  logic [WORD_W-1:0] dn_rdata
);
    rmw_state_t        state_q;
    logic              wr_q;
    logic              err_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        size_q;
    logic [WORD_W-1:0] data_q;

    logic              req_legal;
    logic [WORD_W-1:0] rd_extract;
    logic [WORD_W-1:0] wr_merged;
    logic              accept;

    rmw_legal_check u_legal (
        .ofs   (req_addr[OFS_W-1:0]),
        .size  (req_size),
        .legal (req_legal)
    );

    rmw_lane_extract u_extract (
        .word (dn_rdata),
        .ofs  (addr_q[OFS_W-1:0]),
        .size (size_q),
        .data (rd_extract)
    );

    rmw_lane_merge u_merge (
        .old_word (dn_rdata),
        .new_data (data_q),
        .ofs      (addr_q[OFS_W-1:0]),
        .size     (size_q),
        .merged   (wr_merged)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            err_q   <= 1'b0;
            addr_q  <= '0;
            size_q  <= SZ_BYTE;
            data_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        wr_q   <= req_write;
                        addr_q <= req_addr;
                        size_q <= req_size;
                        data_q <= req_wdata;
                        err_q  <= !req_legal;
                        if (!req_legal)
                            state_q <= ST_RESP;
                        else if (req_write && req_size == SZ_WORD)
                            state_q <= ST_WR_REQ;
                        else
                            state_q <= ST_RD_REQ;
                    end
                end
                ST_RD_REQ: begin
                    if (dn_ready) state_q <= ST_RD_WAIT;
                end
                ST_RD_WAIT: begin
                    if (dn_rvalid) begin
                        if (wr_q) begin
                            data_q  <= wr_merged;
                            state_q <= ST_WR_REQ;
                        end else begin
                            data_q  <= rd_extract;
                            state_q <= ST_RESP;
                        end
                    end
                end
                ST_WR_REQ: begin
                    if (dn_ready) state_q <= ST_WR_WAIT;
                end
                ST_WR_WAIT: begin
                    if (dn_rvalid) state_q <= ST_RESP;
                end
                ST_RESP: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        dn_valid  = 1'b0;
        dn_write  = 1'b0;
        dn_addr   = {addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        dn_wdata  = data_q;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_RD_REQ:  dn_valid  = 1'b1;
            ST_WR_REQ: begin
                dn_valid = 1'b1;
                dn_write = 1'b1;
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                rsp_err   = err_q;
                rsp_rdata = (wr_q || err_q) ? '0 : data_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/subword_rmw_checker.sv
module subword_rmw_checker
    import subword_rmw_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              dn_valid,
    input logic              dn_ready,
    input logic              dn_write,
    input logic [ADDR_W-1:0] dn_addr,
    input logic [WORD_W-1:0] dn_wdata
);
    logic bad_req;
    logic take;
    assign take    = req_valid && req_ready;
    assign bad_req = (req_size == 2'd3)
                  || (req_size == SZ_HALF && req_addr[0])
                  || (req_size == SZ_WORD && req_addr[1:0] != 2'b00);

    p_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> dn_addr[1:0] == 2'b00);

    p_illegal_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take && bad_req |=> rsp_valid && rsp_err && !dn_valid);

    p_narrow_read_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take && !bad_req && (!req_write || req_size != SZ_WORD) |=> dn_valid && !dn_write);

    p_full_write_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take && !bad_req && req_write && req_size == SZ_WORD |=> dn_valid && dn_write);

    p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || dn_valid) |-> !req_ready);

    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_write)
                                && $stable(dn_addr) && $stable(dn_wdata));
endmodule

bind subword_rmw_bridge subword_rmw_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .dn_valid  (dn_valid),
    .dn_ready  (dn_ready),
    .dn_write  (dn_write),
    .dn_addr   (dn_addr),
    .dn_wdata  (dn_wdata)
);

// File: tb/tb_subword_rmw_bridge.sv
module tb_subword_rmw_bridge;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = 2'd0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic          rsp_err;
    logic [31:0]   rsp_rdata;
    logic          dn_valid;
    logic          dn_ready;
    logic          dn_write;
    logic [AW-1:0] dn_addr;
    logic [31:0]   dn_wdata;
    logic          dn_rvalid;
    logic [31:0]   dn_rdata;

    always #5 clk = ~clk;

    subword_rmw_bridge #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
        .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata)
    );

    // downstream word memory model
    logic [31:0] mem [16];
    logic [3:0]  lat_cfg = 4'd0;
    logic        stall_cfg = 1'b0;
    logic        rdy_tog = 1'b0;
    logic        pend = 1'b0;
    logic [3:0]  pend_cnt = '0;
    logic [3:0]  pend_idx = '0;
    logic        rv_q = 1'b0;
    logic [31:0] rd_q = '0;
    int          n_rd = 0;
    int          n_wr = 0;

    assign dn_ready  = stall_cfg ? rdy_tog : 1'b1;
    assign dn_rvalid = rv_q;
    assign dn_rdata  = rd_q;

    always @(posedge clk) begin
        rdy_tog <= ~rdy_tog;
        rv_q    <= 1'b0;
        if (dn_valid && dn_ready && !pend) begin
            pend     <= 1'b1;
            pend_cnt <= lat_cfg;
            pend_idx <= dn_addr[5:2];
            if (dn_write) begin
                mem[dn_addr[5:2]] <= dn_wdata;
                n_wr <= n_wr + 1;
            end else begin
                n_rd <= n_rd + 1;
            end
        end else if (pend) begin
            if (pend_cnt == 0) begin
                rv_q <= 1'b1;
                rd_q <= mem[pend_idx];
                pend <= 1'b0;
            end else begin
                pend_cnt <= pend_cnt - 1;
            end
        end
    end

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] shadow [16];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd, output bit er);
        int guard;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        guard = 0;
        while (!req_ready && guard < 200) begin @(negedge clk); guard++; end
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R7", "ready after accept", 32'(req_ready), 32'd0);
        guard = 0;
        while (!rsp_valid && guard < 200) begin @(negedge clk); guard++; end
        check(rsp_valid == 1'b1, "R7", "response seen", 32'(rsp_valid), 32'd1);
        rd = rsp_rdata;
        er = rsp_err;
        @(negedge clk);
        check(rsp_valid == 1'b0 && req_ready == 1'b1, "R7", "single pulse then idle",
              {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    function automatic bit legal_of(input logic [1:0] o, input logic [1:0] sz);
        if (sz == 2'd3) return 1'b0;
        if (sz == 2'd1) return o[0] == 1'b0;
        if (sz == 2'd2) return o == 2'b00;
        return 1'b1;
    endfunction

    function automatic logic [31:0] lowmask(input logic [1:0] sz);
        if (sz == 2'd0) return 32'h0000_00FF;
        if (sz == 2'd1) return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    initial begin
        logic [31:0] rd;
        logic [31:0] expv;
        logic [31:0] wd;
        logic [31:0] lm;
        bit          er;
        bit          lg;
        int          r0;
        int          w0;
        int          k;
        for (int i = 0; i < 16; i++) begin
            mem[i]    = 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101);
            shadow[i] = 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101);
        end
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0 && dn_valid == 1'b0, "R7",
              "reset state", {29'd0, req_ready, rsp_valid, dn_valid}, 32'h4);
        rst_n = 1'b1;
        k = 0;
        // read sweep: all offsets of a four-word window against every size code
        for (int a = 0; a < 16; a++) begin
            for (int s = 0; s < 4; s++) begin
                lat_cfg = 4'(k % 4); stall_cfg = (k % 3) == 1; k++;
                lg = legal_of(2'(a), 2'(s));
                r0 = n_rd; w0 = n_wr;
                do_req(1'b0, AW'(a + 32), 2'(s), 32'h0, rd, er);
                check(er == !lg, "R3", "read legality flag", 32'(er), 32'(!lg));
                if (lg) begin
                    expv = (shadow[8 + a/4] >> (8 * (a % 4))) & lowmask(2'(s));
                    check(rd == expv, "R2", "read extract", rd, expv);
                    check(n_rd - r0 == 1 && n_wr == w0, "R1", "one aligned read",
                          32'(n_rd - r0), 32'd1);
                end else begin
                    check(rd == 32'h0 && n_rd == r0 && n_wr == w0, "R4",
                          "illegal read no traffic", rd, 32'h0);
                end
            end
        end
        // write sweep
        for (int a = 0; a < 16; a++) begin
            for (int s = 0; s < 4; s++) begin
                lat_cfg = 4'((k * 7) % 5); stall_cfg = (k % 2) == 0; k++;
                lg = legal_of(2'(a), 2'(s));
                wd = 32'hA5C3_0000 ^ (32'(k) * 32'h0103_0507);
                r0 = n_rd; w0 = n_wr;
                do_req(1'b1, AW'(a + 32), 2'(s), wd, rd, er);
                check(er == !lg, "R4", "write error flag", 32'(er), 32'(!lg));
                if (!lg) begin
                    check(n_rd == r0 && n_wr == w0, "R4", "illegal write no traffic",
                          32'(n_wr - w0), 32'd0);
                end else if (s == 2) begin
                    check(n_rd == r0 && n_wr - w0 == 1, "R6", "direct full write",
                          32'(n_rd - r0), 32'd0);
                    shadow[8 + a/4] = wd;
                end else begin
                    check(n_rd - r0 == 1 && n_wr - w0 == 1, "R5", "read then write",
                          32'(n_rd - r0 + n_wr - w0), 32'd2);
                    lm = lowmask(2'(s)) << (8 * (a % 4));
                    shadow[8 + a/4] = (shadow[8 + a/4] & ~lm)
                                    | ((wd & lowmask(2'(s))) << (8 * (a % 4)));
                end
                // read back the affected word whole through the normal port
                do_req(1'b0, AW'(32 + (a/4)*4), 2'd2, 32'h0, rd, er);
                check(rd == shadow[8 + a/4] && !er, (s == 2) ? "R6" : "R5",
                      "word after write", rd, shadow[8 + a/4]);
            end
        end
        // long latency with stalls, address bits above the window (R1, R8)
        lat_cfg = 4'd12; stall_cfg = 1'b1;
        do_req(1'b1, 16'h0037, 2'd0, 32'h0000_005A, rd, er);
        shadow[13] = (shadow[13] & 32'h00FF_FFFF) | 32'h5A00_0000;
        do_req(1'b0, 16'h0034, 2'd2, 32'h0, rd, er);
        check(rd == shadow[13], "R8", "slow port merge", rd, shadow[13]);
        do_req(1'b0, 16'h0036, 2'd1, 32'h0, rd, er);
        check(rd == (shadow[13] >> 16), "R2", "upper half zero-extended", rd, shadow[13] >> 16);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R7 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule